// File: doc/BRIEF.md
# Block Copy Source Line Prefetch Buffer

This block is a small fully associative store that sits beside the first-level data cache. It holds the source lines of a block copy while the copy is running. Software or a copy engine names each source line ahead of use. If that line already lives in the first-level cache, the buffer leaves it alone. Otherwise the buffer claims an entry, marks it pending and sends a fill request to the second level. The returned line lands in the claimed entry. Processor loads probe the buffer in parallel with the cache. A hit returns the selected 32-bit word one cycle later, which is the same delay as a first-level hit. A load that reaches a line whose fill is still outstanding is told to stall and retry.

Destination stores never enter the buffer; they take the normal cache path. Source lines therefore never displace cached data. Eight entries are used because a single-line register would be overwritten before the processor had consumed it. When the copy finishes, every entry is discarded. A snooped write to a buffered line discards that one line.

Top module: `pfb_top`

## Requirements
- R1: While and just after reset, `req_valid`, `ld_hit` and `ld_stall` are low, and a load to any line neither hits nor stalls.
- R2: A prefetch with `pf_in_cache` low, to a line that is neither held nor pending, raises `req_valid` for one cycle on the next cycle. `req_tag` equals the prefetched line address and `req_slot` names the claimed entry.
- R3: A prefetch with `pf_in_cache` high issues no fill request and claims no entry.
- R4: A prefetch to a line that is already held (filled) or pending issues no fill request and claims no entry.
- R5: Entries are claimed in circular order 0,1,...,7,0,... starting at 0 after reset and after every block end. A filled entry at the head of the order is replaced, and its old line is no longer found by loads.
- R6: If the entry at the head of the circular order is still awaiting its fill, a new prefetch is dropped (no request), and the order does not advance.
- R7: A load (`ld_valid`) to a filled line raises `ld_hit` on the next cycle. `ld_data` then carries word `ld_word` of the line, where word k is bits [32k+31:32k] of the fill data.
- R8: A load to a pending line raises `ld_stall` in the same cycle and gives no hit on the next cycle.
- R9: A load to a line not in the buffer gives neither `ld_stall` nor `ld_hit`.
- R10: A `blk_end` pulse discards every entry. A load issued in any later cycle misses. An entry that was pending at block end cannot be claimed again until its fill returns, and that fill does not make its line visible.
- R11: A snooped write (`snoop_valid`) to a held line discards only that line. Later loads to it miss, loads to other lines still hit, and a new prefetch of it is issued again.
- R12: A prefetch presented in the same cycle as `blk_end` issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_valid | input | 1 | Prefetch request for a source line |
| pf_tag | input | 28 | Line address of the prefetch |
| pf_in_cache | input | 1 | The line is already in the first-level cache |
| req_valid | output | 1 | Fill request to the second level |
| req_tag | output | 28 | Line address to fetch |
| req_slot | output | 3 | Entry that the fill must return to |
| fill_valid | input | 1 | Fill data returning from the second level |
| fill_slot | input | 3 | Entry the fill belongs to |
| fill_line | input | 128 | Returned 16-byte line |
| ld_valid | input | 1 | Processor load probe |
| ld_tag | input | 28 | Line address of the load |
| ld_word | input | 2 | 32-bit word within the line |
| ld_stall | output | 1 | Load hit a pending line; retry later |
| ld_hit | output | 1 | Load found a filled line (one cycle after the probe) |
| ld_data | output | 32 | Selected word of the hit line |
| blk_end | input | 1 | The block operation has finished |
| snoop_valid | input | 1 | Snooped write from another agent |
| snoop_tag | input | 28 | Line address of the snooped write |

## Verification
The bench targets the replacement order across wrap-around. A wrong pointer would show up as an unexpected `req_slot` or as a stale line still hitting. It checks that a pending head entry blocks allocation; a design that overwrote it would attach a later fill to the wrong line. It checks that a fill arriving after block end or after a snoop stays invisible and that its entry is not reused early. A design without that guard would either return stale data or hand the entry to a new line that the old fill then corrupts. It also checks duplicate and in-cache filtering and the same-cycle case of a prefetch meeting block end; a wrong design would issue extra fill requests there.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    localparam int PFB_ENTRIES = 8;
    localparam int LINE_BITS   = 128;
    localparam int WORD_BITS   = 32;
    localparam int LINE_AW     = 28;

    localparam int IDX_W  = $clog2(PFB_ENTRIES);
    localparam int WORDS  = LINE_BITS / WORD_BITS;
    localparam int WSEL_W = $clog2(WORDS);

    // DEAD: discarded while a fill was in flight; blocks reuse until that fill drains
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PEND  = 2'd1,
        ST_READY = 2'd2,
        ST_DEAD  = 2'd3
    } slot_state_e;

    typedef struct packed {
        slot_state_e           st;
        logic [LINE_AW-1:0]    tag;
        logic [LINE_BITS-1:0]  line;
    } slot_t;

    function automatic logic is_live(slot_state_e s);
        return (s == ST_PEND) || (s == ST_READY);
    endfunction

    function automatic logic is_free(slot_state_e s);
        return (s == ST_EMPTY) || (s == ST_READY);
    endfunction

    function automatic logic [WORD_BITS-1:0] word_of(logic [LINE_BITS-1:0] ln,
                                                     logic [WSEL_W-1:0] sel);
        return ln[int'(sel)*WORD_BITS +: WORD_BITS];
    endfunction
endpackage

// File: rtl/pfb_slot.sv
module pfb_slot
    import pfb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc,
    input  logic [LINE_AW-1:0]   alloc_tag,
    input  logic                 fill_we,
    input  logic [LINE_BITS-1:0] fill_line,
    input  logic                 kill,
    output slot_t                slot
);
    slot_t q, d;

    always_comb begin
        d = q;
        // returning fill first, then invalidation, then a new claim
        if (fill_we) begin
            if (q.st == ST_PEND) begin
                d.st   = ST_READY;
                d.line = fill_line;
            end else if (q.st == ST_DEAD) begin
                d.st = ST_EMPTY;
            end
        end
        if (kill) begin
            if (d.st == ST_PEND)       d.st = ST_DEAD;
            else if (d.st == ST_READY) d.st = ST_EMPTY;
        end
        if (alloc) begin
            d.st  = ST_PEND;
            d.tag = alloc_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign slot = q;
endmodule

// File: rtl/pfb_alloc.sv
module pfb_alloc
    import pfb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   want,
    input  logic                   restart,
    input  logic [PFB_ENTRIES-1:0] free_vec,
    output logic                   take,
    output logic [IDX_W-1:0]       ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PFB_ENTRIES - 1);

    assign take = want && !restart && free_vec[ptr];

    always_ff @(posedge clk) begin
        if (rst || restart)  ptr <= '0;
        else if (take)       ptr <= (ptr == LAST) ? '0 : ptr + IDX_W'(1);
    end
endmodule

// File: rtl/pfb_lookup.sv
module pfb_lookup
    import pfb_pkg::*;
(
    input  logic                        ld_valid,
    input  logic [LINE_AW-1:0]          ld_tag,
    input  slot_t [PFB_ENTRIES-1:0]     slots,
    output logic                        hit,
    output logic                        stall,
    output logic [LINE_BITS-1:0]        line
);
    always_comb begin
        hit   = 1'b0;
        stall = 1'b0;
        line  = '0;
        for (int i = 0; i < PFB_ENTRIES; i++) begin
            if (slots[i].tag == ld_tag) begin
                if (slots[i].st == ST_READY) begin
                    hit  = hit | ld_valid;
                    line = line | slots[i].line;
                end
                if (slots[i].st == ST_PEND) stall = stall | ld_valid;
            end
        end
    end
endmodule

// File: rtl/pfb_top.sv
module pfb_top
    import pfb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pf_valid,
    input  logic [LINE_AW-1:0]   pf_tag,
    input  logic                 pf_in_cache,
    output logic                 req_valid,
    output logic [LINE_AW-1:0]   req_tag,
    output logic [IDX_W-1:0]     req_slot,
    input  logic                 fill_valid,
    input  logic [IDX_W-1:0]     fill_slot,
    input  logic [LINE_BITS-1:0] fill_line,
    input  logic                 ld_valid,
    input  logic [LINE_AW-1:0]   ld_tag,
    input  logic [WSEL_W-1:0]    ld_word,
    output logic                 ld_stall,
    output logic                 ld_hit,
    output logic [WORD_BITS-1:0] ld_data,
    input  logic                 blk_end,
    input  logic                 snoop_valid,
    input  logic [LINE_AW-1:0]   snoop_tag
);
    slot_t [PFB_ENTRIES-1:0] slots;
    logic  [PFB_ENTRIES-1:0] free_vec, dup_vec, kill_vec, alloc_vec, fill_vec;
    logic                    want, take;
    logic [IDX_W-1:0]        ptr;
    logic                    lk_hit, lk_stall;
    logic [LINE_BITS-1:0]    lk_line;

    for (genvar g = 0; g < PFB_ENTRIES; g++) begin : g_slot
        assign dup_vec[g]   = is_live(slots[g].st) && (slots[g].tag == pf_tag);
        assign free_vec[g]  = is_free(slots[g].st);
        assign kill_vec[g]  = blk_end ||
                              (snoop_valid && is_live(slots[g].st) && (slots[g].tag == snoop_tag));
        assign alloc_vec[g] = take && (ptr == IDX_W'(g));
        assign fill_vec[g]  = fill_valid && (fill_slot == IDX_W'(g));

        pfb_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .alloc     (alloc_vec[g]),
            .alloc_tag (pf_tag),
            .fill_we   (fill_vec[g]),
            .fill_line (fill_line),
            .kill      (kill_vec[g]),
            .slot      (slots[g])
        );
    end

    assign want = pf_valid && !pf_in_cache && !(|dup_vec);

    pfb_alloc u_alloc (
        .clk      (clk),
        .rst      (rst),
        .want     (want),
        .restart  (blk_end),
        .free_vec (free_vec),
        .take     (take),
        .ptr      (ptr)
    );

    pfb_lookup u_lookup (
        .ld_valid (ld_valid),
        .ld_tag   (ld_tag),
        .slots    (slots),
        .hit      (lk_hit),
        .stall    (lk_stall),
        .line     (lk_line)
    );

    assign ld_stall = lk_stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_tag   <= '0;
            req_slot  <= '0;
            ld_hit    <= 1'b0;
            ld_data   <= '0;
        end else begin
            req_valid <= take;
            req_tag   <= pf_tag;
            req_slot  <= ptr;
            ld_hit    <= lk_hit;
            ld_data   <= word_of(lk_line, ld_word);
        end
    end
endmodule

// File: rtl/pfb_checker.sv
module pfb_checker (
    input logic clk,
    input logic rst,
    input logic pf_valid,
    input logic pf_in_cache,
    input logic blk_end,
    input logic req_valid,
    input logic ld_valid,
    input logic ld_stall,
    input logic ld_hit
);
    a_r2_req_has_cause: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($past(pf_valid) && !$past(pf_in_cache)));

    a_r3_cached_skip: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && pf_in_cache) |=> !req_valid);

    a_r12_end_drops_pf: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && blk_end) |=> !req_valid);

    a_r7_hit_needs_load: assert property (@(posedge clk) disable iff (rst)
        ld_hit |-> $past(ld_valid));

    a_r8_stall_needs_load: assert property (@(posedge clk) disable iff (rst)
        ld_stall |-> ld_valid);

    a_r8_stall_blocks_hit: assert property (@(posedge clk) disable iff (rst)
        ld_stall |=> !ld_hit);

    a_r10_end_clears: assert property (@(posedge clk) disable iff (rst)
        $past(blk_end) |=> !ld_hit);
endmodule

bind pfb_top pfb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .pf_valid    (pf_valid),
    .pf_in_cache (pf_in_cache),
    .blk_end     (blk_end),
    .req_valid   (req_valid),
    .ld_valid    (ld_valid),
    .ld_stall    (ld_stall),
    .ld_hit      (ld_hit)
);

// File: tb/sim_pfb_top.sv
module sim_pfb_top;
    import pfb_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 pf_valid, pf_in_cache;
    logic [LINE_AW-1:0]   pf_tag;
    logic                 req_valid;
    logic [LINE_AW-1:0]   req_tag;
    logic [IDX_W-1:0]     req_slot;
    logic                 fill_valid;
    logic [IDX_W-1:0]     fill_slot;
    logic [LINE_BITS-1:0] fill_line;
    logic                 ld_valid;
    logic [LINE_AW-1:0]   ld_tag;
    logic [WSEL_W-1:0]    ld_word;
    logic                 ld_stall, ld_hit;
    logic [WORD_BITS-1:0] ld_data;
    logic                 blk_end, snoop_valid;
    logic [LINE_AW-1:0]   snoop_tag;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfb_top u0 (.*);

    function automatic logic [LINE_BITS-1:0] mk_line(logic [LINE_AW-1:0] a);
        logic [LINE_BITS-1:0] l;
        for (int k = 0; k < WORDS; k++) l[k*WORD_BITS +: WORD_BITS] = {a, 4'(k)};
        return l;
    endfunction

    task automatic chk(string r, logic [127:0] act, logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic pf(logic [LINE_AW-1:0] a, logic incache, logic exp_req,
                      int exp_slot, string r);
        @(negedge clk);
        pf_valid = 1'b1; pf_tag = a; pf_in_cache = incache;
        @(negedge clk);
        pf_valid = 1'b0; pf_in_cache = 1'b0;
        chk(r, 128'(req_valid), 128'(exp_req));
        if (exp_req) begin
            chk(r, 128'(req_tag), 128'(a));
            chk(r, 128'(req_slot), 128'(exp_slot));
        end
    endtask

    task automatic fill(int s, logic [LINE_AW-1:0] a);
        @(negedge clk);
        fill_valid = 1'b1; fill_slot = IDX_W'(s); fill_line = mk_line(a);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic load(logic [LINE_AW-1:0] a, int w, logic exp_stall,
                        logic exp_hit, string r);
        logic [LINE_BITS-1:0] l;
        l = mk_line(a);
        @(negedge clk);
        ld_valid = 1'b1; ld_tag = a; ld_word = WSEL_W'(w);
        #1;
        chk(r, 128'(ld_stall), 128'(exp_stall));
        @(negedge clk);
        ld_valid = 1'b0;
        chk(r, 128'(ld_hit), 128'(exp_hit));
        if (exp_hit) chk(r, 128'(ld_data), 128'(l[w*WORD_BITS +: WORD_BITS]));
    endtask

    task automatic snoop(logic [LINE_AW-1:0] a);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_tag = a;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic end_blk(logic with_pf, logic [LINE_AW-1:0] a);
        @(negedge clk);
        blk_end = 1'b1; pf_valid = with_pf; pf_tag = a; pf_in_cache = 1'b0;
        @(negedge clk);
        blk_end = 1'b0; pf_valid = 1'b0;
        if (with_pf) chk("R12", 128'(req_valid), 128'(0));
    endtask

    task automatic t_reset();
        chk("R1", 128'(req_valid), 128'(0));
        chk("R1", 128'(ld_hit), 128'(0));
        chk("R1", 128'(ld_stall), 128'(0));
        load(28'h005, 0, 1'b0, 1'b0, "R1");
        load(28'h777, 1, 1'b0, 1'b0, "R9");
    endtask

    task automatic t_basic();
        pf(28'h100, 1'b0, 1'b1, 0, "R2");
        load(28'h100, 0, 1'b1, 1'b0, "R8");
        fill(0, 28'h100);
        load(28'h100, 2, 1'b0, 1'b1, "R7");
        load(28'h100, 3, 1'b0, 1'b1, "R7");
    endtask

    task automatic t_filter();
        pf(28'h200, 1'b1, 1'b0, 0, "R3");
        load(28'h200, 0, 1'b0, 1'b0, "R3");
        pf(28'h100, 1'b0, 1'b0, 0, "R4");
        pf(28'h101, 1'b0, 1'b1, 1, "R2");
        pf(28'h101, 1'b0, 1'b0, 0, "R4");
    endtask

    task automatic t_order();
        for (int i = 2; i < 8; i++) pf(28'h100 + 28'(i), 1'b0, 1'b1, i, "R5");
        pf(28'h108, 1'b0, 1'b1, 0, "R5");
        pf(28'h109, 1'b0, 1'b0, 0, "R6");
        load(28'h100, 0, 1'b0, 1'b0, "R5");
        fill(1, 28'h101);
        pf(28'h109, 1'b0, 1'b1, 1, "R6");
        load(28'h101, 0, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_snoop();
        fill(0, 28'h108);
        for (int i = 2; i < 8; i++) fill(i, 28'h100 + 28'(i));
        fill(1, 28'h109);
        load(28'h108, 1, 1'b0, 1'b1, "R11");
        snoop(28'h108);
        load(28'h108, 1, 1'b0, 1'b0, "R11");
        load(28'h105, 3, 1'b0, 1'b1, "R11");
        pf(28'h108, 1'b0, 1'b1, 2, "R11");
    endtask

    task automatic t_end();
        end_blk(1'b0, '0);
        load(28'h103, 0, 1'b0, 1'b0, "R10");
        load(28'h109, 2, 1'b0, 1'b0, "R10");
        pf(28'h300, 1'b0, 1'b1, 0, "R10");
        pf(28'h301, 1'b0, 1'b1, 1, "R10");
        pf(28'h302, 1'b0, 1'b0, 0, "R10");
        fill(2, 28'h108);
        load(28'h108, 0, 1'b0, 1'b0, "R10");
        pf(28'h302, 1'b0, 1'b1, 2, "R10");
    endtask

    task automatic t_end_pf();
        fill(0, 28'h300);
        fill(1, 28'h301);
        fill(2, 28'h302);
        load(28'h301, 1, 1'b0, 1'b1, "R7");
        end_blk(1'b1, 28'h500);
        load(28'h301, 1, 1'b0, 1'b0, "R10");
        pf(28'h500, 1'b0, 1'b1, 0, "R12");
    endtask

    initial begin
        rst = 1'b1;
        pf_valid = 1'b0; pf_tag = '0; pf_in_cache = 1'b0;
        fill_valid = 1'b0; fill_slot = '0; fill_line = '0;
        ld_valid = 1'b0; ld_tag = '0; ld_word = '0;
        blk_end = 1'b0; snoop_valid = 1'b0; snoop_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_filter();
        t_order();
        t_snoop();
        t_end();
        t_end_pf();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule